// File: doc/BRIEF.md
# Bit-Alias Bus Bridge

This bridge sits between a 32-bit processor port and a 32-bit memory-mapped bus. It gives software single-bit access to a target region. Each bit of that region has its own 32-bit word in an alias window. Accesses that fall outside the alias window go to the bus unchanged.

An alias read fetches the target word and returns the chosen bit as the value 0 or 1. The processor waits until that value is ready. An alias write is posted, so the processor is released in the cycle it is accepted. The bridge then reads the target word, replaces the chosen bit and writes the whole word back. A lock output stays high for both phases, so no other master can reach the bus in between.

The write-back uses the word captured by the read. A flag that hardware sets in the target word between the two phases is therefore overwritten. This is a known hazard of bit-granular writes to hardware-set, write-to-clear status registers. The bridge keeps this behaviour visible rather than hiding it.

Top module: `bitband_bridge`

## Requirements
- R1: Alias address mapping. For an access at `ALIAS_BASE + off` with `off < TARGET_BYTES*32`:
  - the target word is at `TARGET_BASE + 4*(off/128)`;
  - the selected bit position is `8*((off/32) mod 4) + (off/4) mod 8`.
  An alias read returns 32'h0000_0001 when that bit is set and 32'h0000_0000 otherwise.
- R2: An alias read issues exactly one unlocked bus read of the target word. `s_ack` rises only in the cycle the bus returns `m_ack`, that is `lat+2` negedges after the request is first driven, where `lat` is the number of extra bus wait cycles.
- R3: An alias write issues a bus read of the target word and then a bus write to the same address. The written word equals the word read, with only the selected bit replaced by bit 0 of `s_wdata`. Bits 31..1 of `s_wdata` have no effect.
- R4: `m_lock` is high on both transactions of an alias write and stays high from the read phase through the write-back. It is low again once the write-back completes.
- R5: A write request that arrives while the bridge is idle is acknowledged in the same cycle it is presented. This holds for alias and pass-through writes.
- R6: A processor request presented while an alias read-modify-write is still running is not acknowledged until the write-back has completed on the bus.
- R7: A read outside the alias window issues one unlocked bus read at the same address and returns the bus data unchanged.
- R8: A write outside the alias window issues one unlocked bus write at the same address with the same data.
- R9: Only one bus transaction is outstanding at a time. While `m_req` is high and `m_ack` is low, `m_req`, `m_we`, `m_addr` and `m_wdata` hold their values into the next cycle.
- R10: The write-back of an alias write takes all unselected bits from the value captured by its read phase. The bridge does not re-read the target, even if the target word changes after that read.
- R11: While `rst_n` is low, `m_req`, `m_lock` and `s_ack` are low.
- R12: The alias window is `[ALIAS_BASE, ALIAS_BASE + TARGET_BYTES*32)`. The last word inside it is decoded as an alias access. The words just below and just above it are passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Processor request, held until `s_ack` |
| s_we | input | 1 | Processor write enable |
| s_addr | input | 32 | Processor byte address |
| s_wdata | input | 32 | Processor write data |
| s_ack | output | 1 | Request completed; for reads, `s_rdata` is valid |
| s_rdata | output | 32 | Processor read data |
| m_req | output | 1 | Bus request, held until `m_ack` |
| m_we | output | 1 | Bus write enable |
| m_addr | output | 32 | Bus byte address |
| m_wdata | output | 32 | Bus write data |
| m_lock | output | 1 | Bus lock during an alias read-modify-write |
| m_ack | input | 1 | Bus transaction done; for reads, `m_rdata` is valid |
| m_rdata | input | 32 | Bus read data |

## Verification
The bench builds the bridge with `TARGET_BYTES = 16`, `TARGET_BASE = 32'h200` and `ALIAS_BASE = 32'h4000`. That gives 128 alias words, which the bench sweeps completely for reads, for writes and for a read-back. This reaches every bit position of every target word, and also both window edges and the addresses just outside them.

The bus model rotates its latency between 0 and 2 wait cycles. On some alias writes it sets extra bits in the target word right after the locked read. This shows that the write-back keeps the captured value. An alias write followed at once by another request exercises the stall and the order of the bus transactions.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] TARGET_BASE  = 32'h2000_0000,
  parameter int          TARGET_BYTES = 1 << 20
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_ack,
  output logic [31:0] s_rdata,
  output logic        m_req,
  output logic        m_we,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  output logic        m_lock,
  input  logic        m_ack,
  input  logic [31:0] m_rdata
);
  localparam logic [31:0] ALIAS_SPAN = 32'(TARGET_BYTES) << 5;

  typedef enum logic [2:0] {IDLE, RD, RMW_RD, RMW_WR, PT_WR} state_t;

  state_t      state;
  logic [31:0] addr_q, wdata_q;
  logic [4:0]  pos_q;
  logic        alias_q, bit_q;

  logic [31:0] alias_off, tgt_addr;
  logic        in_alias;

  assign alias_off = s_addr - ALIAS_BASE;
  assign in_alias  = (s_addr >= ALIAS_BASE) && (alias_off < ALIAS_SPAN);
  assign tgt_addr  = TARGET_BASE + ((alias_off >> 7) << 2);

  assign m_req   = (state != IDLE);
  assign m_we    = (state == RMW_WR) || (state == PT_WR);
  assign m_lock  = (state == RMW_RD) || (state == RMW_WR);
  assign m_addr  = addr_q;
  assign m_wdata = wdata_q;

  assign s_ack   = ((state == IDLE) && s_req && s_we) || ((state == RD) && m_ack);
  assign s_rdata = alias_q ? {31'd0, m_rdata[pos_q]} : m_rdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      pos_q   <= '0;
      alias_q <= 1'b0;
      bit_q   <= 1'b0;
    end else begin
      case (state)
        IDLE: if (s_req) begin
          alias_q <= in_alias;
          pos_q   <= alias_off[6:2];
          bit_q   <= s_wdata[0];
          addr_q  <= in_alias ? tgt_addr : s_addr;
          wdata_q <= s_wdata;
          if (!s_we)         state <= RD;
          else if (in_alias) state <= RMW_RD;
          else               state <= PT_WR;
        end
        RMW_RD: if (m_ack) begin
          wdata_q <= (m_rdata & ~(32'd1 << pos_q)) | ({31'd0, bit_q} << pos_q);
          state   <= RMW_WR;
        end
        RD, RMW_WR, PT_WR: if (m_ack) state <= IDLE;
        default: state <= IDLE;
      endcase
    end
  end

  // R9
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_ack) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R4
  lock_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_ack && !m_we) |=> (m_lock && m_req && m_we));

  // R4
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_lock && m_ack && m_we) |=> !m_lock);

  // R5
  posted_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_req && s_we && !m_req) |-> s_ack);

  // R6
  rmw_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_lock |-> !s_ack);

  // R1
  alias_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ack && !s_we && alias_q) |-> (s_rdata[31:1] == 31'd0));
endmodule

// File: tb/bitband_bridge_bench.sv
module bitband_bridge_bench;
  localparam logic [31:0] ABASE = 32'h0000_4000;
  localparam logic [31:0] TBASE = 32'h0000_0200;
  localparam int          TBYTES = 16;
  localparam int          NALIAS = TBYTES * 8;

  logic clk = 0, rst_n = 0;
  logic s_req = 0, s_we = 0;
  logic [31:0] s_addr = 0, s_wdata = 0;
  logic s_ack;
  logic [31:0] s_rdata;
  logic m_req, m_we, m_lock;
  logic [31:0] m_addr, m_wdata;
  logic m_ack;
  logic [31:0] m_rdata;

  bitband_bridge #(.ALIAS_BASE(ABASE), .TARGET_BASE(TBASE), .TARGET_BYTES(TBYTES)) u_bitband_bridge (
    .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_ack(s_ack), .s_rdata(s_rdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_lock(m_lock), .m_ack(m_ack), .m_rdata(m_rdata));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  int lat = 0;
  logic [31:0] inject = 0;
  logic [31:0] mem [16];
  logic [31:0] rmem [16];
  int cnt = 0;
  int lidx = 0;
  logic        log_we [1024];
  logic        log_lock [1024];
  logic [31:0] log_addr [1024];
  logic [31:0] log_data [1024];

  function automatic logic [31:0] pat(input int k);
    return (32'h9E37_79B9 * 32'(k + 1)) ^ 32'h5A5A_0000;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 0; m_rdata <= 0; cnt <= 0;
      for (int k = 0; k < 16; k++) mem[k] <= pat(k);
    end else begin
      m_ack <= 0;
      if (m_req && !m_ack) begin
        if (cnt == lat) begin
          m_ack <= 1; cnt <= 0;
          if (m_we) mem[m_addr[5:2]] <= m_wdata;
          else begin
            m_rdata <= mem[m_addr[5:2]];
            if (m_lock) mem[m_addr[5:2]] <= mem[m_addr[5:2]] | inject;
          end
          log_we[lidx % 1024]   <= m_we;
          log_lock[lidx % 1024] <= m_lock;
          log_addr[lidx % 1024] <= m_addr;
          log_data[lidx % 1024] <= m_we ? m_wdata : mem[m_addr[5:2]];
          lidx <= lidx + 1;
        end else cnt <= cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R9 monitor: request fields hold while waiting for m_ack
  logic pv_pend = 0, pv_we = 0;
  logic [31:0] pv_addr = 0, pv_wd = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_pend) chk(m_req && m_we == pv_we && m_addr == pv_addr && m_wdata == pv_wd,
                       "R9 bus hold", m_addr, pv_addr);
      pv_pend <= m_req && !m_ack;
      pv_we <= m_we; pv_addr <= m_addr; pv_wd <= m_wdata;
    end
  end

  task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int waits);
    @(negedge clk);
    s_req = 1; s_we = we; s_addr = a; s_wdata = d; waits = 0;
    #1;
    while (!s_ack) begin
      @(negedge clk); #1; waits++;
    end
    rd = s_rdata;
    @(posedge clk); #1;
    s_req = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (m_req) @(negedge clk);
  endtask

  function automatic int word_of(input int off);
    return (off / 32) / 4;
  endfunction
  function automatic int pos_of(input int off);
    return 8 * ((off / 32) % 4) + (off / 4) % 8;
  endfunction

  task automatic alias_read_sweep(input string tag);
    for (int i = 0; i < NALIAS; i++) begin
      logic [31:0] rd, exp;
      int w, lb, off;
      off = 4 * i; w = word_of(off); lat = i % 3; lb = lidx;
      exp = {31'd0, rmem[w][pos_of(off)]};
      access(0, ABASE + 32'(off), 32'hDEAD_BEEF, rd, w);
      w = word_of(off);
      chk(rd == exp, {tag, " R1 alias read value"}, rd, exp);
      chk(lidx - lb == 1 && !log_we[lb % 1024] && !log_lock[lb % 1024] &&
          log_addr[lb % 1024] == TBASE + 32'(4 * w), "R2 alias read bus access",
          log_addr[lb % 1024], TBASE + 32'(4 * w));
    end
  endtask

  int wd_cnt = 0;
  initial begin : wd
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int waits, lb;
    for (int k = 0; k < 16; k++) rmem[k] = pat(k);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!m_req && !m_lock && !s_ack, "R11 reset outputs", {29'd0, m_req, m_lock, s_ack}, 0);
    rst_n = 1;

    // R2 latency: measured on one read per latency
    for (int l = 0; l < 3; l++) begin
      lat = l;
      access(0, ABASE + 32'(4 * l), 0, rd, waits);
      chk(waits == l + 2, "R2 alias read stall", waits, l + 2);
    end

    alias_read_sweep("first");

    // R3 R4 R5 R10 write sweep
    for (int i = 0; i < NALIAS; i++) begin
      int off, w, p;
      logic b;
      logic [31:0] prev, exp;
      off = 4 * i; w = word_of(off); p = pos_of(off);
      lat = i % 3;
      b = ((i / 3) % 2) == 1;
      inject = (i % 4 == 1) ? (32'd1 << ((i * 5) % 32)) : 32'd0;
      prev = rmem[w];
      exp = prev; exp[p] = b;
      lb = lidx;
      access(1, ABASE + 32'(off), {pat(i + 7)} & 32'hFFFF_FFFE | {31'd0, b}, rd, waits);
      chk(waits == 0, "R5 alias write posted", waits, 0);
      wait_idle();
      chk(!m_lock, "R4 lock released", {31'd0, m_lock}, 0);
      chk(lidx - lb == 2, "R3 two bus transactions", lidx - lb, 2);
      chk(!log_we[lb % 1024] && log_lock[lb % 1024] && log_addr[lb % 1024] == TBASE + 32'(4 * w),
          "R4 locked read phase", log_addr[lb % 1024], TBASE + 32'(4 * w));
      chk(log_we[(lb + 1) % 1024] && log_lock[(lb + 1) % 1024] &&
          log_addr[(lb + 1) % 1024] == TBASE + 32'(4 * w),
          "R4 locked write phase", log_addr[(lb + 1) % 1024], TBASE + 32'(4 * w));
      chk(log_data[(lb + 1) % 1024] == exp, "R3 R10 write-back data", log_data[(lb + 1) % 1024], exp);
      rmem[w] = exp;
    end
    inject = 0;

    alias_read_sweep("after-write");

    // R7 R8 R12 pass-through and window edges
    begin
      logic [31:0] pa [4];
      pa[0] = ABASE - 4; pa[1] = ABASE + 32'(NALIAS * 4); pa[2] = 32'h0000_0030; pa[3] = 32'hFFFF_FFFC;
      for (int j = 0; j < 4; j++) begin
        logic [31:0] d;
        lat = j % 3;
        lb = lidx;
        access(0, pa[j], 0, rd, waits);
        chk(rd == rmem[pa[j][5:2]], "R7 R12 pass read data", rd, rmem[pa[j][5:2]]);
        chk(lidx - lb == 1 && !log_we[lb % 1024] && !log_lock[lb % 1024] && log_addr[lb % 1024] == pa[j],
            "R7 R12 pass read bus", log_addr[lb % 1024], pa[j]);
        d = pat(j + 40);
        lb = lidx;
        access(1, pa[j], d, rd, waits);
        chk(waits == 0, "R5 R8 pass write posted", waits, 0);
        wait_idle();
        chk(lidx - lb == 1 && log_we[lb % 1024] && !log_lock[lb % 1024] &&
            log_addr[lb % 1024] == pa[j] && log_data[lb % 1024] == d,
            "R8 pass write bus", log_data[lb % 1024], d);
        rmem[pa[j][5:2]] = d;
      end
      // R12 last alias word: bit 31 of last target word
      lat = 0;
      access(0, ABASE + 32'(NALIAS * 4 - 4), 0, rd, waits);
      chk(rd == {31'd0, rmem[TBYTES / 4 - 1][31]}, "R12 last alias word", rd,
          {31'd0, rmem[TBYTES / 4 - 1][31]});
    end

    // R6 back-to-back: write then read stalls behind write-back
    for (int l = 0; l < 3; l++) begin
      int w2;
      lat = l;
      lb = lidx;
      access(1, ABASE + 32'(4 * l), {31'd0, ~rmem[0][l]}, rd, waits);
      chk(waits == 0, "R5 posted before stall", waits, 0);
      access(0, 32'h0000_0034, 0, rd, w2);
      rmem[0][l] = ~rmem[0][l];
      chk(w2 >= 2 * l + 3, "R6 stall length", w2, 2 * l + 3);
      chk(lidx - lb == 3 && log_we[(lb + 1) % 1024] && !log_we[(lb + 2) % 1024] &&
          !log_lock[(lb + 2) % 1024] && log_addr[(lb + 2) % 1024] == 32'h34,
          "R6 order write-back before next", log_addr[(lb + 2) % 1024], 32'h34);
      chk(rd == rmem[13], "R6 R7 read after write", rd, rmem[13]);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule